// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between a 16-bit CPU and its Flash and RAM arrays. The 64 KiB address space is cut into four 16 KiB windows. The lowest window always shows Flash page 00h. The other three each show a page chosen by a selector register that software writes through an I/O port. For every address it reports whether the access goes to Flash or to RAM, the page number seen by software, the physical array address and whether an opcode fetch has landed on an execution-protected RAM page.

Two windows use a mixed selector: bit 7 chooses between RAM and Flash, and the page bits are masked differently for each case. The top window is RAM-only and uses a 3-bit select. A mode input models hardware with reduced RAM, where several RAM page numbers share one physical page. Selectors read back as the full stored byte, so code can save a mapping, borrow a page and put the old mapping back.

Top module: `bank_window_mapper`

## Requirements
- R1: Addresses 0000h-3FFFh always go to Flash page 00h: `mem_is_ram`=0, `mem_lpage`=00h, `mem_phys`={6'h00, addr[13:0]}. No selector affects this window.
- R2: For the 4000h-7FFFh window (selector on I/O port 06h) and the 8000h-BFFFh window (selector on I/O port 07h), a selector with bit 7 clear maps Flash page (selector AND 3Fh). `mem_phys`={page[5:0], addr[13:0]}.
- R3: For those same two windows, a selector with bit 7 set maps RAM page 80h OR (selector AND 07h). `mem_lpage` carries that page number.
- R4: The C000h-FFFFh window (selector on I/O port 05h) always maps RAM page 80h OR (selector AND 07h). The upper selector bits are ignored.
- R5: Reset sets port 06h to 00h, port 07h to 81h and port 05h to 00h. A read of ports 05h, 06h or 07h returns the full stored byte. A read of any other port returns 00h, and a write to any other port changes no selector.
- R6: A selector write, sampled at a rising clock edge with `io_wr`=1, changes the translation right after that edge. The translation is combinational from `cpu_addr` and the stored selectors.
- R7: With `ram_reduced`=0, a RAM access gives `mem_phys`={page[2:0], addr[13:0]}, zero-extended.
- R8: With `ram_reduced`=1, RAM pages 82h-87h all give physical index 2, so `mem_phys`={3'd2, addr[13:0]}. Pages 80h and 81h keep indices 0 and 1. `mem_lpage` still shows the selected page number.
- R9: `exec_viol` is 1 exactly when `mem_fetch`=1 and the access goes to RAM page 80h, 82h, 84h or 86h. Data accesses and Flash fetches never raise it.
- R10: Each window translates on its own. The same RAM page selected in two windows gives the same physical address for the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_addr | input | 8 | I/O port number for writes and reads |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Selector byte for the addressed port, 00h for other ports |
| cpu_addr | input | 16 | CPU memory address |
| mem_fetch | input | 1 | Current memory cycle is an opcode fetch |
| ram_reduced | input | 1 | 1 selects the reduced-RAM aliasing mode |
| mem_is_ram | output | 1 | 1 when the access targets RAM, 0 for Flash |
| mem_lpage | output | 8 | Page number as software sees it (Flash 00h-3Fh, RAM 80h-87h) |
| mem_phys | output | 20 | Physical address inside the targeted array |
| exec_viol | output | 1 | Opcode fetch from an execution-protected RAM page |

## Verification
The assertions check these rules on every cycle: the fixed Flash mapping of the bottom window, the RAM-only top window, the physical address layout in both RAM modes, the conditions that allow a protection flag, and that each selector changes only after a write to its own port with exactly the written byte. Some things only the bench's scenarios can show. These are the page number each selector encoding produces in each window, the reset values seen through port reads, and the case of one page mapped into two windows at once. Another is the mode-dependent aliasing seen from the address bus.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  // Address-space windows, indexed by cpu_addr[15:14]
  typedef enum logic [1:0] {
    WIN_FIXED = 2'd0,
    WIN_LOW   = 2'd1,
    WIN_MID   = 2'd2,
    WIN_HIGH  = 2'd3
  } win_e;

  localparam int unsigned NUM_SEL = 3;
endpackage

// File: rtl/bwm_rst_sync.sv
module bwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/bwm_sel_regs.sv
module bwm_sel_regs #(
  parameter int unsigned SEL_W = 8,
  parameter int unsigned IO_W  = 8,
  parameter int unsigned NUM   = 3,
  parameter logic [NUM*IO_W-1:0]  PORT_IDS = '0,
  parameter logic [NUM*SEL_W-1:0] RST_VALS = '0
) (
  input  logic                 clk,
  input  logic                 rst_q,
  input  logic                 io_wr,
  input  logic [IO_W-1:0]      io_addr,
  input  logic [SEL_W-1:0]     io_wdata,
  output logic [NUM*SEL_W-1:0] sel_flat,
  output logic [SEL_W-1:0]     io_rdata
);
  logic [NUM-1:0] hit;

  for (genvar g = 0; g < NUM; g++) begin : g_sel
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_d;
    logic             sel_en;

    assign hit[g] = (io_addr == PORT_IDS[g*IO_W +: IO_W]);

    always_comb begin
      sel_en = io_wr && hit[g];
      sel_d  = io_wdata;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q)      sel_q <= RST_VALS[g*SEL_W +: SEL_W];
      else if (sel_en) sel_q <= sel_d;
    end

    assign sel_flat[g*SEL_W +: SEL_W] = sel_q;
  end

  always_comb begin
    io_rdata = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hit[i]) io_rdata = io_rdata | sel_flat[i*SEL_W +: SEL_W];
    end
  end
endmodule

// File: rtl/bwm_win_xlate.sv
module bwm_win_xlate #(
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned FLASH_PG_W = 6,
  parameter int unsigned RAM_PG_W   = 3,
  parameter bit          RAM_ONLY   = 1'b0
) (
  input  logic [SEL_W-1:0] sel,
  output logic             is_ram,
  output logic [SEL_W-1:0] lpage
);
  localparam logic [SEL_W-1:0] RAM_BASE = SEL_W'(1) << (SEL_W - 1);

  logic [SEL_W-1:0] ram_page;
  logic [SEL_W-1:0] flash_page;

  assign ram_page   = RAM_BASE | SEL_W'(sel[RAM_PG_W-1:0]);
  assign flash_page = SEL_W'(sel[FLASH_PG_W-1:0]);

  if (RAM_ONLY) begin : g_ram_only
    assign is_ram = 1'b1;
    assign lpage  = ram_page;
  end else begin : g_mixed
    assign is_ram = sel[SEL_W-1];
    assign lpage  = sel[SEL_W-1] ? ram_page : flash_page;
  end
endmodule

// File: rtl/bwm_phys_map.sv
module bwm_phys_map #(
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned WIN_W      = 14,
  parameter int unsigned FLASH_PG_W = 6,
  parameter int unsigned RAM_PG_W   = 3,
  parameter int unsigned ALIAS_IDX  = 2,
  parameter int unsigned PHYS_W     = 20
) (
  input  logic              is_ram,
  input  logic [SEL_W-1:0]  lpage,
  input  logic [WIN_W-1:0]  offset,
  input  logic              reduced,
  input  logic              fetch,
  output logic [PHYS_W-1:0] phys,
  output logic              viol
);
  localparam logic [RAM_PG_W-1:0] ALIAS = RAM_PG_W'(ALIAS_IDX);
  localparam logic [RAM_PG_W-1:0] FIRST_SHARED = RAM_PG_W'(2);

  logic [RAM_PG_W-1:0] ram_sel;
  logic [RAM_PG_W-1:0] ram_idx;

  always_comb begin
    ram_sel = lpage[RAM_PG_W-1:0];
    ram_idx = ram_sel;
    if (reduced && (ram_sel >= FIRST_SHARED)) ram_idx = ALIAS;
  end

  always_comb begin
    if (is_ram) phys = PHYS_W'({ram_idx, offset});
    else        phys = PHYS_W'({lpage[FLASH_PG_W-1:0], offset});
  end

  // Even RAM page numbers are execution-protected
  assign viol = fetch && is_ram && !ram_sel[0];
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IO_W       = 8,
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned FLASH_PG_W = 6,
  parameter int unsigned RAM_PG_W   = 3,
  parameter int unsigned ALIAS_IDX  = 2,
  parameter logic [7:0]  PORT_LOW   = 8'h06,
  parameter logic [7:0]  PORT_MID   = 8'h07,
  parameter logic [7:0]  PORT_HIGH  = 8'h05,
  parameter logic [7:0]  RST_LOW    = 8'h00,
  parameter logic [7:0]  RST_MID    = 8'h81,
  parameter logic [7:0]  RST_HIGH   = 8'h00,
  parameter int unsigned PHYS_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [SEL_W-1:0]  io_wdata,
  output logic [SEL_W-1:0]  io_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_fetch,
  input  logic              ram_reduced,
  output logic              mem_is_ram,
  output logic [SEL_W-1:0]  mem_lpage,
  output logic [PHYS_W-1:0] mem_phys,
  output logic              exec_viol
);
  import bwm_pkg::*;

  localparam int unsigned WIN_W = ADDR_W - 2;
  localparam int unsigned NSEL  = NUM_SEL;

  logic                  rst_q;
  logic [NSEL*SEL_W-1:0] sel_flat;
  logic [SEL_W-1:0]      sel_a;
  logic [SEL_W-1:0]      sel_b;
  logic [SEL_W-1:0]      sel_c;
  logic [NSEL-1:0]       w_ram;
  logic [SEL_W-1:0]      w_page [NSEL];
  win_e                  win;
  logic                  cur_ram;
  logic [SEL_W-1:0]      cur_page;

  bwm_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  bwm_sel_regs #(
    .SEL_W    (SEL_W),
    .IO_W     (IO_W),
    .NUM      (NSEL),
    .PORT_IDS ({IO_W'(PORT_HIGH), IO_W'(PORT_MID), IO_W'(PORT_LOW)}),
    .RST_VALS ({SEL_W'(RST_HIGH), SEL_W'(RST_MID), SEL_W'(RST_LOW)})
  ) sel_regs_i (
    .clk      (clk),
    .rst_q    (rst_q),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .sel_flat (sel_flat),
    .io_rdata (io_rdata)
  );

  assign sel_a = sel_flat[0*SEL_W +: SEL_W];
  assign sel_b = sel_flat[1*SEL_W +: SEL_W];
  assign sel_c = sel_flat[2*SEL_W +: SEL_W];

  // One translator per selected window; the last one is RAM-only
  for (genvar g = 0; g < NSEL; g++) begin : g_win
    bwm_win_xlate #(
      .SEL_W      (SEL_W),
      .FLASH_PG_W (FLASH_PG_W),
      .RAM_PG_W   (RAM_PG_W),
      .RAM_ONLY   (g == NSEL - 1)
    ) xlate_i (
      .sel    (sel_flat[g*SEL_W +: SEL_W]),
      .is_ram (w_ram[g]),
      .lpage  (w_page[g])
    );
  end

  always_comb begin
    win = win_e'(cpu_addr[ADDR_W-1 -: 2]);
    unique case (win)
      WIN_FIXED: begin cur_ram = 1'b0;     cur_page = '0;        end
      WIN_LOW:   begin cur_ram = w_ram[0]; cur_page = w_page[0]; end
      WIN_MID:   begin cur_ram = w_ram[1]; cur_page = w_page[1]; end
      default:   begin cur_ram = w_ram[2]; cur_page = w_page[2]; end
    endcase
  end

  bwm_phys_map #(
    .SEL_W      (SEL_W),
    .WIN_W      (WIN_W),
    .FLASH_PG_W (FLASH_PG_W),
    .RAM_PG_W   (RAM_PG_W),
    .ALIAS_IDX  (ALIAS_IDX),
    .PHYS_W     (PHYS_W)
  ) phys_i (
    .is_ram  (cur_ram),
    .lpage   (cur_page),
    .offset  (cpu_addr[WIN_W-1:0]),
    .reduced (ram_reduced),
    .fetch   (mem_fetch),
    .phys    (mem_phys),
    .viol    (exec_viol)
  );

  assign mem_is_ram = cur_ram;
  assign mem_lpage  = cur_page;
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker (
  input logic        clk,
  input logic        rst_q,
  input logic        io_wr,
  input logic [7:0]  io_addr,
  input logic [7:0]  io_wdata,
  input logic [15:0] cpu_addr,
  input logic        mem_fetch,
  input logic        ram_reduced,
  input logic        mem_is_ram,
  input logic [7:0]  mem_lpage,
  input logic [19:0] mem_phys,
  input logic        exec_viol,
  input logic [7:0]  sel_a,
  input logic [7:0]  sel_b,
  input logic [7:0]  sel_c
);
  assert_win0_flash_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_addr[15:14] == 2'd0) |-> (!mem_is_ram && mem_phys == {6'h00, cpu_addr[13:0]}));

  assert_top_ram_only_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_addr[15:14] == 2'd3) |-> (mem_is_ram && mem_lpage[7:3] == 5'b10000));

  assert_full_ram_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_is_ram && !ram_reduced) |-> (mem_phys == {3'b000, mem_lpage[2:0], cpu_addr[13:0]}));

  assert_alias_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_is_ram && ram_reduced && mem_lpage[2:1] != 2'b00)
      |-> (mem_phys == {3'b000, 3'd2, cpu_addr[13:0]}));

  assert_viol_cause_R9: assert property (@(posedge clk) disable iff (!rst_q)
    exec_viol |-> (mem_fetch && mem_is_ram && !mem_lpage[0]));

  assert_wr_low_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (io_wr && io_addr == 8'h06) |=> (sel_a == $past(io_wdata)));

  assert_wr_mid_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (io_wr && io_addr == 8'h07) |=> (sel_b == $past(io_wdata)));

  assert_wr_high_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (io_wr && io_addr == 8'h05) |=> (sel_c == $past(io_wdata)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_q)
    !(io_wr && (io_addr == 8'h05 || io_addr == 8'h06 || io_addr == 8'h07))
      |=> ($stable(sel_a) && $stable(sel_b) && $stable(sel_c)));
endmodule

bind bank_window_mapper bwm_checker chk_i (.*);

// File: tb/bank_window_mapper_tb_top.sv
`timescale 1ns/1ps
module bank_window_mapper_tb_top;
  typedef struct packed {
    logic [7:0]  port;
    logic [7:0]  data;
    logic [15:0] addr;
    logic        fetch;
    logic        red;
    logic        e_ram;
    logic [7:0]  e_page;
    logic [19:0] e_phys;
    logic        e_viol;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    {8'h07, 8'h83, 16'h8123, 1'b0, 1'b0, 1'b1, 8'h83, 20'h0C123, 1'b0},
    {8'h06, 8'h83, 16'h4123, 1'b0, 1'b0, 1'b1, 8'h83, 20'h0C123, 1'b0},
    {8'h06, 8'h05, 16'h7FFF, 1'b0, 1'b0, 1'b0, 8'h05, 20'h17FFF, 1'b0},
    {8'h06, 8'h7F, 16'h4000, 1'b0, 1'b0, 1'b0, 8'h3F, 20'hFC000, 1'b0},
    {8'h05, 8'h02, 16'hC010, 1'b0, 1'b0, 1'b1, 8'h82, 20'h08010, 1'b0},
    {8'h05, 8'hFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 8'h87, 20'h1FFFF, 1'b0},
    {8'h05, 8'hFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 8'h87, 20'h0BFFF, 1'b0},
    {8'h07, 8'h81, 16'h8000, 1'b0, 1'b1, 1'b1, 8'h81, 20'h04000, 1'b0},
    {8'h05, 8'h00, 16'hC000, 1'b1, 1'b0, 1'b1, 8'h80, 20'h00000, 1'b1},
    {8'h07, 8'h81, 16'h8001, 1'b1, 1'b0, 1'b1, 8'h81, 20'h04001, 1'b0},
    {8'h10, 8'hAA, 16'h0123, 1'b1, 1'b0, 1'b0, 8'h00, 20'h00123, 1'b0},
    {8'h07, 8'h8E, 16'h9000, 1'b1, 1'b0, 1'b1, 8'h86, 20'h19000, 1'b1},
    {8'h06, 8'hC4, 16'h4000, 1'b1, 1'b1, 1'b1, 8'h84, 20'h08000, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        io_wr;
  logic [7:0]  io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [15:0] cpu_addr;
  logic        mem_fetch;
  logic        ram_reduced;
  logic        mem_is_ram;
  logic [7:0]  mem_lpage;
  logic [19:0] mem_phys;
  logic        exec_viol;

  int n_cmp;
  int n_bad;
  logic [19:0] phys_first;

  bank_window_mapper dut_i (
    .clk (clk), .rst_n (rst_n),
    .io_wr (io_wr), .io_addr (io_addr), .io_wdata (io_wdata), .io_rdata (io_rdata),
    .cpu_addr (cpu_addr), .mem_fetch (mem_fetch), .ram_reduced (ram_reduced),
    .mem_is_ram (mem_is_ram), .mem_lpage (mem_lpage), .mem_phys (mem_phys),
    .exec_viol (exec_viol)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic port_write(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = p; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic port_read(input logic [7:0] p, input string what, input logic [7:0] exp);
    io_addr = p;
    #1;
    check(what, 32'(io_rdata), 32'(exp));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    cpu_addr = '0; mem_fetch = 1'b0; ram_reduced = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: reset values
    port_read(8'h06, "R5 reset port 06h", 8'h00);
    port_read(8'h07, "R5 reset port 07h", 8'h81);
    port_read(8'h05, "R5 reset port 05h", 8'h00);
    port_read(8'h33, "R5 unmapped port read", 8'h00);
    // R1 with reset mapping, R2 Flash page 00h at 4000h
    cpu_addr = 16'h2ABC; #1;
    check("R1 window0 ram", 32'(mem_is_ram), 32'd0);
    check("R1 window0 phys", 32'(mem_phys), 32'h02ABC);
    cpu_addr = 16'h5000; #1;
    check("R2 reset low window phys", 32'(mem_phys), 32'h01000);

    // Table walk: R2 R3 R4 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      port_write(VECS[i].port, VECS[i].data);
      cpu_addr = VECS[i].addr; mem_fetch = VECS[i].fetch; ram_reduced = VECS[i].red;
      #1;
      check($sformatf("R2/R3/R4 target vec %0d", i), 32'(mem_is_ram), 32'(VECS[i].e_ram));
      check($sformatf("R2/R3/R4 page vec %0d", i), 32'(mem_lpage), 32'(VECS[i].e_page));
      check($sformatf("R7/R8 phys vec %0d", i), 32'(mem_phys), 32'(VECS[i].e_phys));
      check($sformatf("R9 viol vec %0d", i), 32'(exec_viol), 32'(VECS[i].e_viol));
    end
    mem_fetch = 1'b0; ram_reduced = 1'b0;

    // R5: full byte readback and unrelated port write ignored
    port_write(8'h07, 8'hF3);
    port_read(8'h07, "R5 readback port 07h", 8'hF3);
    port_write(8'h04, 8'h55);
    port_read(8'h07, "R5 port 07h after foreign write", 8'hF3);
    port_read(8'h06, "R5 port 06h after foreign write", 8'hC4);
    port_read(8'h05, "R5 port 05h after foreign write", 8'h00);

    // R6: translation changes right after the write edge, not before
    cpu_addr = 16'hC222;
    @(negedge clk);
    io_wr = 1'b1; io_addr = 8'h05; io_wdata = 8'h03;
    #1;
    check("R6 before edge phys", 32'(mem_phys), 32'h00222);
    @(posedge clk); #1;
    io_wr = 1'b0;
    check("R6 after edge phys", 32'(mem_phys), 32'h0C222);

    // R10: page 85h in two windows, same bytes
    port_write(8'h06, 8'h85);
    port_write(8'h07, 8'h85);
    cpu_addr = 16'h4555; #1;
    phys_first = mem_phys;
    cpu_addr = 16'h8555; #1;
    check("R10 dual map same phys", 32'(mem_phys), 32'(phys_first));
    check("R10 dual map value", 32'(phys_first), 32'h14555);

    // R9: data access to protected page raises nothing; Flash fetch neither
    port_write(8'h05, 8'h04);
    cpu_addr = 16'hD000; mem_fetch = 1'b0; #1;
    check("R9 data access page 84h", 32'(exec_viol), 32'd0);
    cpu_addr = 16'h1000; mem_fetch = 1'b1; #1;
    check("R9 flash fetch", 32'(exec_viol), 32'd0);
    mem_fetch = 1'b0;

    // R5: asynchronous reset mid-run restores selectors
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    port_read(8'h07, "R5 mid-run reset port 07h", 8'h81);
    port_read(8'h06, "R5 mid-run reset port 06h", 8'h00);
    port_read(8'h05, "R5 mid-run reset port 05h", 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule